// File: doc/BRIEF.md
# RGB to Luma/Chroma Converter with Chroma Subsampling

This block is the streaming front end of a baseline still-image encoder. It accepts one 8-bit RGB pixel per clock in raster order. Each pixel is converted to one luminance value and two colour-difference values with signed Q2.14 fixed-point coefficients. The luminance stream leaves at full resolution with a fixed two-edge latency. The colour-difference values are averaged over small pixel groups before they leave, which lowers the chroma sample rate.

The `modeVert` input selects the averaging group. With `modeVert` = 0 the block averages over 2×1 groups (4:2:2, horizontal only). With `modeVert` = 1 it averages over 2×2 groups (4:2:0, horizontal and vertical). Vertical averaging keeps one line of horizontally summed chroma pairs in an internal buffer. Lines are marked by `lineStart`, and frames by `frameStart`. The `lineWidth` input gives the number of pixels in every line.

Top module: `chroma_sub_top`

## Requirements
- R1: Pixels are packed as `pixRgb` = {R[23:16], G[15:8], B[7:0]}. Y = floor((4899·R + 9617·G + 1868·B + 8192) / 16384), clamped to 0..255. Y for a pixel sampled on rising edge k is on `yData` after edge k+1.
- R2: Cb = floor((−2765·R − 5427·G + 8192·B + 2105344) / 16384), clamped to 0..255. The constant 2105344 is 128·16384 plus the rounding half.
- R3: Cr = floor((8192·R − 6860·G − 1332·B + 2105344) / 16384), clamped to 0..255.
- R4: A conversion result above 255 saturates to 255 and a result below 0 saturates to 0. For example, pure blue gives Cb = 255 and pure red gives Cr = 255.
- R5: `yValid` is high for exactly one cycle per accepted pixel, two edges after the pixel is sampled. Back-to-back pixels are accepted, and idle input cycles produce idle output cycles.
- R6: With `modeVert` = 0, every horizontal pair (columns 2k and 2k+1) produces one chroma output: (a + b + 1) >> 1 for each of Cb and Cr. `cValid` rises after the third rising edge that follows the edge sampling column 2k+1.
- R7: With `modeVert` = 1, lines with even row index produce no chroma output. On an odd row, column 2k+1 produces (sum of the four Cb or Cr values of columns 2k and 2k+1 on this row and the row above + 2) >> 2, with the same timing as R6.
- R8: `frameStart` sets the row index to 0 and the column to 0. `lineStart` without `frameStart` starts column 0 of the next row. In 4:2:0 mode, a frame with an odd line count emits no chroma for its last line.
- R9: While `rstN` is low, and until the first accepted pixel has passed through the pipeline, `yValid` and `cValid` stay low.
- R10: `modeVert` is sampled together with each pixel. A change between frames applies from the first pixel of the next frame.
- R11: `lineWidth` is even and at most `MAX_WIDTH`. Every line carries exactly `lineWidth` pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pixValid | input | 1 | Pixel present on `pixRgb` this cycle |
| pixRgb | input | 24 | Pixel as {R, G, B}, 8 bits each |
| lineStart | input | 1 | Marks the first pixel of a line |
| frameStart | input | 1 | Marks the first pixel of a frame |
| lineWidth | input | $clog2(MAX_WIDTH+1) | Pixels per line, even |
| modeVert | input | 1 | 0: 2×1 chroma averaging, 1: 2×2 chroma averaging |
| yValid | output | 1 | Luminance sample valid |
| yData | output | 8 | Luminance sample |
| cValid | output | 1 | Chroma pair valid |
| cbData | output | 8 | Averaged blue-difference sample |
| crData | output | 8 | Averaged red-difference sample |

## Verification
The assertions check these behaviours on every clock:
- `yValid` follows accepted pixels exactly two edges later.
- A chroma output only ever follows an odd-column pixel.
- An even row in 4:2:0 mode never produces chroma.
- The input line protocol holds: even width, no column beyond `lineWidth`, and a new line only after a full one.

The numeric results need the bench's reference model and chosen scenarios. These results are:
- the coefficient arithmetic and its rounding;
- saturation on pure primaries;
- the two averaging formulas;
- dropping the chroma of a trailing unpaired line;
- a mode switch between frames.

// File: rtl/chroma_sub_pkg.sv
package chroma_sub_pkg;

  localparam int PIX_W  = 8;
  localparam int COEF_W = 16;
  localparam int FRAC   = 14;
  localparam int ACC_W  = 32;
  localparam int SUM2_W = PIX_W + 1;
  localparam int SUM4_W = PIX_W + 2;

  localparam logic signed [ACC_W-1:0] HALF_LSB   = ACC_W'(1 << (FRAC - 1));
  localparam logic signed [ACC_W-1:0] CHROMA_OFS = ACC_W'((128 << FRAC) + (1 << (FRAC - 1)));

  // Strobes handed from control to datapath, aligned with the clamped samples
  typedef struct packed {
    logic valid;
    logic colOdd;
    logic rowOdd;
    logic vert;
  } pixCtl_t;

  // Q2.14 matrix: channel 0 luma, 1 blue difference, 2 red difference; k picks R, G, B
  function automatic logic signed [COEF_W-1:0] coefOf(input int ch, input int k);
    case (ch * 3 + k)
      0:       return 16'sd4899;
      1:       return 16'sd9617;
      2:       return 16'sd1868;
      3:       return -16'sd2765;
      4:       return -16'sd5427;
      5:       return 16'sd8192;
      6:       return 16'sd8192;
      7:       return -16'sd6860;
      default: return -16'sd1332;
    endcase
  endfunction

  function automatic logic signed [ACC_W-1:0] biasOf(input int ch);
    return (ch == 0) ? HALF_LSB : CHROMA_OFS;
  endfunction

  function automatic logic [PIX_W-1:0] sat8(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] q;
    q = acc >>> FRAC;
    if (q < 0)        return '0;
    else if (q > 255) return '1;
    else              return q[PIX_W-1:0];
  endfunction

endpackage

// File: rtl/chroma_sub_ctrl.sv
module chroma_sub_ctrl
  import chroma_sub_pkg::*;
#(
  parameter int MAX_WIDTH = 64,
  parameter int COL_W     = 7,
  parameter int IDX_W     = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic             lineStart,
  input  logic             frameStart,
  input  logic             modeVert,
  input  logic [COL_W-1:0] lineWidth,
  output pixCtl_t          ctlOut,
  output logic [IDX_W-1:0] pairIdxOut
);

  logic [COL_W-1:0] colReg, curCol;
  logic             rowReg, curRow;
  pixCtl_t          ctlA;
  logic [IDX_W-1:0] idxA;

  // Position of the pixel on the input this cycle
  always_comb begin
    curCol = (lineStart || frameStart) ? '0 : colReg;
    if (frameStart)     curRow = 1'b0;
    else if (lineStart) curRow = ~rowReg;
    else                curRow = rowReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colReg <= '0;
      rowReg <= 1'b0;
    end else if (pixValid) begin
      colReg <= curCol + COL_W'(1);
      rowReg <= curRow;
    end
  end

  // Two stages to line up with the conversion and clamp stages
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlA       <= '0;
      idxA       <= '0;
      ctlOut     <= '0;
      pairIdxOut <= '0;
    end else begin
      ctlA.valid  <= pixValid;
      ctlA.colOdd <= curCol[0];
      ctlA.rowOdd <= curRow;
      ctlA.vert   <= modeVert;
      idxA        <= curCol[IDX_W:1];
      ctlOut      <= ctlA;
      pairIdxOut  <= idxA;
    end
  end

  assert_even_width_R11: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> !lineWidth[0]);

  assert_col_in_line_R11: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> (curCol < lineWidth));

  assert_line_complete_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && lineStart && !frameStart) |-> (colReg == lineWidth));

endmodule

// File: rtl/chroma_sub_dp.sv
module chroma_sub_dp
  import chroma_sub_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [23:0]      pixRgb,
  input  pixCtl_t          ctlIn,
  input  logic [IDX_W-1:0] pairIdxIn,
  output logic             yValid,
  output logic [PIX_W-1:0] yData,
  output logic             cValid,
  output logic [PIX_W-1:0] cbData,
  output logic [PIX_W-1:0] crData
);

  function automatic logic signed [ACC_W-1:0] mac3(
    input logic [23:0] rgb,
    input logic signed [COEF_W-1:0] kr, kg, kb,
    input logic signed [ACC_W-1:0] bias
  );
    logic signed [ACC_W-1:0] r, g, b;
    r = ACC_W'($signed({1'b0, rgb[23:16]}));
    g = ACC_W'($signed({1'b0, rgb[15:8]}));
    b = ACC_W'($signed({1'b0, rgb[7:0]}));
    return r * ACC_W'(kr) + g * ACC_W'(kg) + b * ACC_W'(kb) + bias;
  endfunction

  // Conversion: multiply-accumulate stage, then clamp stage
  for (genvar ch = 0; ch < 3; ch++) begin : g_conv
    logic signed [ACC_W-1:0] accA;
    logic [PIX_W-1:0]        satB;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) accA <= '0;
      else       accA <= mac3(pixRgb, coefOf(ch, 0), coefOf(ch, 1), coefOf(ch, 2), biasOf(ch));
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) satB <= '0;
      else       satB <= sat8(accA);
    end
  end

  assign yValid = ctlIn.valid;
  assign yData  = g_conv[0].satB;

  // Pair stage control
  logic             vldC, rowOddC, vertC;
  logic [IDX_W-1:0] idxC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldC    <= 1'b0;
      rowOddC <= 1'b0;
      vertC   <= 1'b0;
      idxC    <= '0;
    end else begin
      vldC    <= ctlIn.valid && ctlIn.colOdd;
      rowOddC <= ctlIn.rowOdd;
      vertC   <= ctlIn.vert;
      idxC    <= pairIdxIn;
    end
  end

  // Chroma channels: horizontal pair sum, shared line of pair sums, averaging
  for (genvar c = 0; c < 2; c++) begin : g_chr
    logic [PIX_W-1:0]  holdB;
    logic [SUM2_W-1:0] sumC;
    logic [SUM2_W-1:0] lineMem [DEPTH];
    logic [SUM2_W-1:0] aboveSum;
    logic [SUM2_W:0]   avg2Raw;
    logic [SUM4_W-1:0] avg4Raw;
    logic [PIX_W-1:0]  outD;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdB <= '0;
        sumC  <= '0;
      end else begin
        if (ctlIn.valid && !ctlIn.colOdd) holdB <= g_conv[c+1].satB;
        sumC <= {1'b0, holdB} + {1'b0, g_conv[c+1].satB};
      end
    end

    always_ff @(posedge clk) begin
      if (vldC && vertC && !rowOddC) lineMem[idxC] <= sumC;
    end

    always_comb begin
      aboveSum = lineMem[idxC];
      avg2Raw  = {1'b0, sumC} + (SUM2_W+1)'(1);
      avg4Raw  = {1'b0, aboveSum} + {1'b0, sumC} + SUM4_W'(2);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     outD <= '0;
      else if (vldC) outD <= vertC ? avg4Raw[SUM4_W-1:2] : avg2Raw[SUM2_W:1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cValid <= 1'b0;
    else       cValid <= vldC && (!vertC || rowOddC);
  end

  assign cbData = g_chr[0].outD;
  assign crData = g_chr[1].outD;

  assert_even_row_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    (vldC && vertC && !rowOddC) |=> !cValid);

  assert_chroma_after_odd_col_R6: assert property (@(posedge clk) disable iff (!rstN)
    cValid |-> $past(ctlIn.valid && ctlIn.colOdd, 2));

endmodule

// File: rtl/chroma_sub_top.sv
module chroma_sub_top
  import chroma_sub_pkg::*;
#(
  parameter  int MAX_WIDTH = 64,
  localparam int LW_W      = $clog2(MAX_WIDTH + 1),
  localparam int DEPTH     = MAX_WIDTH / 2,
  localparam int IDX_W     = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pixValid,
  input  logic [23:0]     pixRgb,
  input  logic            lineStart,
  input  logic            frameStart,
  input  logic [LW_W-1:0] lineWidth,
  input  logic            modeVert,
  output logic            yValid,
  output logic [7:0]      yData,
  output logic            cValid,
  output logic [7:0]      cbData,
  output logic [7:0]      crData
);

  pixCtl_t          ctlB;
  logic [IDX_W-1:0] pairIdxB;

  chroma_sub_ctrl #(.MAX_WIDTH(MAX_WIDTH), .COL_W(LW_W), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .lineStart(lineStart),
    .frameStart(frameStart), .modeVert(modeVert), .lineWidth(lineWidth),
    .ctlOut(ctlB), .pairIdxOut(pairIdxB)
  );

  chroma_sub_dp #(.DEPTH(DEPTH), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .pixRgb(pixRgb), .ctlIn(ctlB), .pairIdxIn(pairIdxB),
    .yValid(yValid), .yData(yData), .cValid(cValid), .cbData(cbData), .crData(crData)
  );

  // Edges seen since reset, saturating, so the latency check never looks before reset
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  assert_y_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd2) |-> (yValid == $past(pixValid, 2)));

endmodule

// File: tb/chroma_sub_top_tb_top.sv
module chroma_sub_top_tb_top;

  localparam int MAXW = 64;
  localparam int LWW  = $clog2(MAXW + 1);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            pixValid = 1'b0, lineStart = 1'b0, frameStart = 1'b0, modeVert = 1'b0;
  logic [23:0]     pixRgb = '0;
  logic [LWW-1:0]  lineWidth = LWW'(8);
  logic            yValid, cValid;
  logic [7:0]      yData, cbData, crData;

  chroma_sub_top #(.MAX_WIDTH(MAXW)) dut_i (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixRgb(pixRgb),
    .lineStart(lineStart), .frameStart(frameStart), .lineWidth(lineWidth),
    .modeVert(modeVert), .yValid(yValid), .yData(yData), .cValid(cValid),
    .cbData(cbData), .crData(crData)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFails = 0;
  string tag = "R9";

  // Reference model state
  int yAt[$], yExp[$], cAt[$], cbExp[$], crExp[$];
  int row = 0, col = 0;
  bit curMode = 1'b0;
  int lineCb[2][MAXW], lineCr[2][MAXW];

  task automatic report(input string req, input string what, input int act, input int expv);
    nFails++;
    $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
  endtask

  function automatic string valTag(input string base, input int expv);
    return (expv == 0 || expv == 255) ? "R4" : base;
  endfunction

  // Conversion straight from R1, R2 and R3
  function automatic int conv(input int ch, input int r, input int g, input int b);
    int acc, q;
    case (ch)
      0:       acc = 4899 * r + 9617 * g + 1868 * b + 8192;
      1:       acc = -2765 * r - 5427 * g + 8192 * b + 2105344;
      default: acc = 8192 * r - 6860 * g - 1332 * b + 2105344;
    endcase
    q = acc >>> 14;
    if (q < 0) q = 0;
    if (q > 255) q = 255;
    return q;
  endfunction

  // Cycle-by-cycle comparison against the expectation queues
  always @(negedge clk) begin
    bit yWant, cWant;
    yWant = (yAt.size() > 0) && (yAt[0] == cyc);
    cWant = (cAt.size() > 0) && (cAt[0] == cyc);
    nChecks++;
    if (yValid !== yWant) report("R5", "yValid", int'(yValid), int'(yWant));
    else if (yWant && yData !== yExp[0][7:0]) report(valTag("R1", yExp[0]), "yData", yData, yExp[0]);
    if (yWant) begin void'(yAt.pop_front()); void'(yExp.pop_front()); end
    nChecks++;
    if (cValid !== cWant) report(tag, "cValid", int'(cValid), int'(cWant));
    else if (cWant) begin
      if (cbData !== cbExp[0][7:0]) report(valTag("R2", cbExp[0]), "cbData", cbData, cbExp[0]);
      if (crData !== crExp[0][7:0]) report(valTag("R3", crExp[0]), "crData", crData, crExp[0]);
    end
    if (cWant) begin void'(cAt.pop_front()); void'(cbExp.pop_front()); void'(crExp.pop_front()); end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      pixValid = 1'b0; lineStart = 1'b0; frameStart = 1'b0;
    end
  endtask

  task automatic sendPix(input int r, input int g, input int b, input bit ls, input bit fs);
    int y, cb, cr, p, sCb, sCr;
    @(negedge clk);
    pixValid = 1'b1; pixRgb = {r[7:0], g[7:0], b[7:0]};
    lineStart = ls; frameStart = fs; modeVert = curMode;
    if (fs) begin row = 0; col = 0; end
    else if (ls) begin row++; col = 0; end
    y = conv(0, r, g, b); cb = conv(1, r, g, b); cr = conv(2, r, g, b);
    yAt.push_back(cyc + 2); yExp.push_back(y);
    p = row % 2;
    lineCb[p][col] = cb; lineCr[p][col] = cr;
    if (col % 2 == 1) begin
      if (!curMode) begin
        // R6: pair average with rounding
        cAt.push_back(cyc + 4);
        cbExp.push_back((lineCb[p][col-1] + cb + 1) / 2);
        crExp.push_back((lineCr[p][col-1] + cr + 1) / 2);
      end else if (p == 1) begin
        // R7: 2x2 average with rounding
        sCb = lineCb[0][col-1] + lineCb[0][col] + lineCb[1][col-1] + lineCb[1][col];
        sCr = lineCr[0][col-1] + lineCr[0][col] + lineCr[1][col-1] + lineCr[1][col];
        cAt.push_back(cyc + 4);
        cbExp.push_back((sCb + 2) / 4);
        crExp.push_back((sCr + 2) / 4);
      end
    end
    col++;
  endtask

  task automatic sendFrame(input bit mode, input int width, input int lines,
                           input int gapEvery, input int seed, input bit primaries);
    idle(2);
    lineWidth = LWW'(width);
    curMode = mode;
    for (int ln = 0; ln < lines; ln++) begin
      for (int c = 0; c < width; c++) begin
        logic [31:0] h;
        int r, g, b;
        h = (seed * 4096 + ln * 128 + c) * 32'h9E3779B1;
        h = h ^ (h >> 13);
        r = h[23:16]; g = h[15:8]; b = h[7:0];
        if (primaries && ln == 0) begin
          case (c)
            0: begin r = 255; g = 255; b = 255; end
            1: begin r = 0;   g = 0;   b = 0;   end
            2: begin r = 255; g = 0;   b = 0;   end
            3: begin r = 255; g = 0;   b = 0;   end
            4: begin r = 0;   g = 0;   b = 255; end
            5: begin r = 0;   g = 0;   b = 255; end
            default: ;
          endcase
        end
        if (gapEvery > 0 && c % gapEvery == gapEvery - 1) idle(1);
        sendPix(r, g, b, c == 0, ln == 0 && c == 0);
      end
    end
    idle(1);
  endtask

  initial begin
    // R9: quiet outputs in reset and just after release
    repeat (3) begin
      @(negedge clk);
      nChecks++;
      if (yValid !== 1'b0 || cValid !== 1'b0) report("R9", "valid in reset", int'(yValid | cValid), 0);
    end
    rstN = 1'b1;
    @(negedge clk);
    nChecks++;
    if (yValid !== 1'b0 || cValid !== 1'b0) report("R9", "valid after reset", int'(yValid | cValid), 0);

    tag = "R6";  sendFrame(1'b0, 8, 2, 3, 1, 1'b1);   // 2x1 averaging, gaps, saturating primaries
    tag = "R7";  sendFrame(1'b1, 8, 4, 0, 2, 1'b0);   // 2x2 averaging, back to back
    tag = "R8";  sendFrame(1'b1, 6, 3, 0, 3, 1'b1);   // odd line count: last line silent
    tag = "R11"; sendFrame(1'b1, MAXW, 2, 0, 4, 1'b0); // full-width lines fill the line buffer
    tag = "R10"; sendFrame(1'b0, 4, 2, 0, 5, 1'b1);   // mode switched back between frames
    idle(12);

    nChecks++;
    if (yAt.size() != 0 || cAt.size() != 0)
      report("R5", "outputs left unmatched", yAt.size() + cAt.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule